// File: doc/BRIEF.md
# Video Sample-to-Word Packer

This block sits between a parallel video receive path and a host memory write path. It takes 20-bit video samples, one per accepted cycle, and packs every three of them into two 32-bit words. The words leave on a valid/ready stream. A frame-start flag and a line-end flag mark where the active picture begins and where each line ends, so the host side can lay the words out in memory without parsing them.

The upstream path marks the last sample of each line with `in_eol_i`. It may mark the first sample of a frame with `in_sof_i` to bring the internal line counter back to zero. The block counts lines modulo the frame height and counts samples within each line. With the default 1920 by 1080 picture, a line packs into 1280 words and a frame into 5,529,600 bytes. A line whose length is not a multiple of three has its last group zero-filled. A line whose length differs from the configured width is flagged on its final word. Backpressure on the output holds off the input, and no sample is lost or repeated.

Top module: `vid_word_packer`

## Requirements
- R1: After reset, `out_valid_o` is low and `in_ready_o` is high.
- R2: For samples a, b, c accepted in that order within a group, the first word is `{b[11:0], a[19:0]}` and the second word is `{4'b0000, c[19:0], b[19:12]}`. The first word is emitted before the second.
- R3: Every group of accepted samples yields exactly two output words. Under any pattern of `out_ready_i`, no word is dropped or repeated. While `out_valid_o` is high and `out_ready_i` is low, the output data and flags hold their values.
- R4: `out_eol_o` is high on the second word of the group that holds the sample accepted with `in_eol_i`, and on no other word.
- R5: Lines are numbered from 0 after reset, and each accepted `in_eol_i` advances the number, wrapping to 0 after FRAME_LINES lines. `out_sof_o` is high only on the first word of the first group of a line numbered 0.
- R6: A sample accepted with `in_sof_i` as the first sample of a line makes that line number 0.
- R7: A line that ends with one or two samples left over emits a final group in which the missing samples are zero. The next line always starts a new group.
- R8: `out_err_o` is high on the final word of a line whose sample count differs from LINE_SAMPLES, and low on every other word.
- R9: `in_ready_o` is low only while a group is held at the output and its second word is not being taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can take a sample |
| in_data_i | input | 20 | Video sample |
| in_sof_i | input | 1 | First sample of a frame (resets the line number) |
| in_eol_i | input | 1 | Last sample of a line |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the word |
| out_data_o | output | 32 | Packed word |
| out_sof_o | output | 1 | First word of a frame |
| out_eol_o | output | 1 | Last word of a line |
| out_err_o | output | 1 | Line length differed from LINE_SAMPLES |

## Verification
The bench targets lines of 1, 9, 10, 11 and 14 samples. A packer that does not clear its group phase at a line end would spread the next line's samples across the wrong words. A packer without zero fill would leak stale samples into the padded slots. The bench also checks the line-number wrap and the frame-start resync: a counter off by one moves the frame-start flag to the wrong line. Random and fully held output backpressure expose any word that is lost, repeated, or changed while stalled.

// File: rtl/vwp_pkg.sv
package vwp_pkg;
  localparam int unsigned SAMPLE_W = 20;
  localparam int unsigned WORD_W   = 32;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [WORD_W-1:0]   word_t;

  typedef struct packed {
    word_t w0;
    word_t w1;
    logic  sof;
    logic  eol;
    logic  err;
  } group_t;

  // three samples -> two words, top nibble of w1 is pad
  function automatic group_t pack_group(sample_t a, sample_t b, sample_t c,
                                        logic sof, logic eol, logic err);
    group_t g;
    g.w0  = {b[11:0], a};
    g.w1  = {4'b0000, c, b[19:12]};
    g.sof = sof;
    g.eol = eol;
    g.err = err;
    return g;
  endfunction
endpackage

// File: rtl/vwp_line_track.sv
module vwp_line_track #(
  parameter int unsigned LINE_SAMPLES = 1920,
  parameter int unsigned FRAME_LINES  = 1080
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic sof_i,
  input  logic eol_i,
  output logic first_o,
  output logic line_zero_o,
  output logic len_bad_o
);
  localparam int unsigned CNT_W = $clog2(LINE_SAMPLES + 2);
  localparam int unsigned IDX_W = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_SAMPLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LINES - 1);

  logic [CNT_W-1:0] samp_cnt;
  logic [IDX_W-1:0] line_idx, cur_idx;

  assign first_o     = (samp_cnt == '0);
  assign cur_idx     = (first_o && sof_i) ? '0 : line_idx;
  assign line_zero_o = (cur_idx == '0);
  assign len_bad_o   = (samp_cnt != CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_cnt <= '0;
      line_idx <= '0;
    end else if (acc_i) begin
      if (eol_i) begin
        samp_cnt <= '0;
        line_idx <= (cur_idx == IDX_LAST) ? '0 : cur_idx + IDX_W'(1);
      end else begin
        if (samp_cnt != '1) samp_cnt <= samp_cnt + CNT_W'(1);
        line_idx <= cur_idx;
      end
    end
  end
endmodule

// File: rtl/vwp_group_acc.sv
module vwp_group_acc
  import vwp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acc_i,
  input  sample_t data_i,
  input  logic    eol_i,
  input  logic    line_first_i,
  input  logic    line_zero_i,
  input  logic    len_bad_i,
  output logic    grp_vld_o,
  output group_t  grp_o
);
  logic [1:0] phase;
  sample_t    s0_q, s1_q;
  sample_t    a, b, c;
  logic       sof_q, sof_now;

  assign sof_now   = (phase == 2'd0) ? (line_first_i && line_zero_i) : sof_q;
  assign grp_vld_o = acc_i && (eol_i || phase == 2'd2);

  always_comb begin
    case (phase)
      2'd0:    begin a = data_i; b = '0;     c = '0;     end
      2'd1:    begin a = s0_q;   b = data_i; c = '0;     end
      default: begin a = s0_q;   b = s1_q;   c = data_i; end
    endcase
    grp_o = pack_group(a, b, c, sof_now, eol_i, eol_i && len_bad_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= 2'd0;
      s0_q  <= '0;
      s1_q  <= '0;
      sof_q <= 1'b0;
    end else if (acc_i) begin
      phase <= grp_vld_o ? 2'd0 : phase + 2'd1;
      if (phase == 2'd0) begin
        s0_q  <= data_i;
        sof_q <= sof_now;
      end
      if (phase == 2'd1) s1_q <= data_i;
    end
  end
endmodule

// File: rtl/vwp_out_stage.sv
module vwp_out_stage
  import vwp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  group_t grp_i,
  input  logic   out_ready_i,
  output logic   free_o,
  output logic   out_valid_o,
  output word_t  out_data_o,
  output logic   out_sof_o,
  output logic   out_eol_o,
  output logic   out_err_o
);
  logic   vld, idx;
  group_t grp_q;

  assign free_o      = !vld || (idx && out_ready_i);
  assign out_valid_o = vld;
  assign out_data_o  = idx ? grp_q.w1 : grp_q.w0;
  assign out_sof_o   = vld && !idx && grp_q.sof;
  assign out_eol_o   = vld && idx && grp_q.eol;
  assign out_err_o   = vld && idx && grp_q.err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld   <= 1'b0;
      idx   <= 1'b0;
      grp_q <= '0;
    end else if (load_i) begin
      vld   <= 1'b1;
      idx   <= 1'b0;
      grp_q <= grp_i;
    end else if (vld && out_ready_i) begin
      if (idx) vld <= 1'b0;
      idx <= ~idx;
    end
  end
endmodule

// File: rtl/vid_word_packer.sv
module vid_word_packer
  import vwp_pkg::*;
#(
  parameter int unsigned LINE_SAMPLES = 1920,
  parameter int unsigned FRAME_LINES  = 1080
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [19:0] in_data_i,
  input  logic        in_sof_i,
  input  logic        in_eol_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_data_o,
  output logic        out_sof_o,
  output logic        out_eol_o,
  output logic        out_err_o
);
  logic   acc, first, line_zero, len_bad, grp_vld, free;
  group_t grp;

  assign in_ready_o = free;
  assign acc        = in_valid_i && free;

  vwp_line_track #(
    .LINE_SAMPLES(LINE_SAMPLES),
    .FRAME_LINES (FRAME_LINES)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .sof_i      (in_sof_i),
    .eol_i      (in_eol_i),
    .first_o    (first),
    .line_zero_o(line_zero),
    .len_bad_o  (len_bad)
  );

  vwp_group_acc u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .data_i      (in_data_i),
    .eol_i       (in_eol_i),
    .line_first_i(first),
    .line_zero_i (line_zero),
    .len_bad_i   (len_bad),
    .grp_vld_o   (grp_vld),
    .grp_o       (grp)
  );

  vwp_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (grp_vld),
    .grp_i      (grp),
    .out_ready_i(out_ready_i),
    .free_o     (free),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_sof_o  (out_sof_o),
    .out_eol_o  (out_eol_o),
    .out_err_o  (out_err_o)
  );
endmodule

// File: rtl/vwp_checker.sv
module vwp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_i,
  input logic       out_valid_i,
  input logic       out_ready_i,
  input logic [31:0] out_data_i,
  input logic       out_sof_i,
  input logic       out_eol_i,
  input logic       out_err_i
);
  p_ready_needs_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_i |-> out_valid_i);

  p_hold_on_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i) &&
      $stable(out_sof_i) && $stable(out_eol_i) && $stable(out_err_i)));

  p_pad_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_eol_i) |-> (out_data_i[31:28] == 4'b0000));

  p_sof_first_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_i |-> (out_valid_i && !out_eol_i));

  p_err_on_eol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_i |-> out_eol_i);
endmodule

bind vid_word_packer vwp_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_i (in_ready_o),
  .out_valid_i(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_i (out_data_o),
  .out_sof_i  (out_sof_o),
  .out_eol_i  (out_eol_o),
  .out_err_i  (out_err_o)
);

// File: tb/vid_word_packer_tb.sv
module vid_word_packer_tb;
  localparam int LS = 12;
  localparam int FL = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_sof_i = 1'b0, in_eol_i = 1'b0;
  logic [19:0] in_data_i = '0;
  logic        in_ready_o, out_valid_o, out_sof_o, out_eol_o, out_err_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;

  int checks = 0, errors = 0;
  int bp_mode = 0;
  int mline = 0;
  logic [34:0] exp_q[$];
  logic [34:0] got_q[$];
  logic [19:0] smp [0:63];

  always #10 clk = ~clk;

  vid_word_packer #(.LINE_SAMPLES(LS), .FRAME_LINES(FL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_sof_i(in_sof_i), .in_eol_i(in_eol_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eol_o(out_eol_o), .out_err_o(out_err_o)
  );

  // ready driver and output monitor
  always begin
    @(negedge clk);
    out_ready_i = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
    #1;
    if (rst_ni && out_valid_o && out_ready_i)
      got_q.push_back({out_err_o, out_eol_o, out_sof_o, out_data_o});
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model plus driver for one line of n samples
  task automatic send_line(input int n, input bit sof);
    int cur;
    logic [19:0] a, b, c;
    bit last, zero, bad;
    for (int i = 0; i < n; i++) smp[i] = 20'($urandom);
    cur  = sof ? 0 : mline;
    zero = (cur == 0);
    bad  = (n != LS);
    for (int g = 0; 3 * g < n; g++) begin
      a = smp[3*g];
      b = (3*g + 1 < n) ? smp[3*g+1] : 20'h0;
      c = (3*g + 2 < n) ? smp[3*g+2] : 20'h0;
      last = (3*g + 3 >= n);
      exp_q.push_back({1'b0, 1'b0, (g == 0) && zero, b[11:0], a});
      exp_q.push_back({last && bad, last, 1'b0, 4'h0, c, b[19:12]});
    end
    mline = (cur == FL - 1) ? 0 : cur + 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = smp[i];
      in_eol_i   = (i == n - 1);
      in_sof_i   = sof && (i == 0);
      #1;
      while (!in_ready_o) begin
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid_i = 1'b0;
    in_eol_i   = 1'b0;
    in_sof_i   = 1'b0;
  endtask

  task automatic compare(input string req);
    int m;
    idle_in();
    for (int k = 0; k < 4000 && got_q.size() < exp_q.size(); k++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk({req, " word count"}, 64'(got_q.size()), 64'(exp_q.size()));
    m = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < m; i++) chk(req, 64'(got_q[i]), 64'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    chk("R1 out_valid after reset", 64'(out_valid_o), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready_o), 64'd1);
  endtask

  task automatic t_frame();
    send_line(LS, 1'b1);
    send_line(LS, 1'b0);
    send_line(LS, 1'b0);
    compare("R2 R4 R5 full frame");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) send_line(LS, 1'b0);
    compare("R5 line wrap");
  endtask

  task automatic t_resync();
    send_line(LS, 1'b0);
    send_line(LS, 1'b1);
    send_line(LS, 1'b0);
    compare("R6 sof resync");
  endtask

  task automatic t_short();
    send_line(10, 1'b0);
    send_line(11, 1'b0);
    send_line(9, 1'b0);
    send_line(1, 1'b0);
    send_line(LS, 1'b0);
    send_line(14, 1'b0);
    compare("R7 R8 odd line lengths");
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    send_line(LS, 1'b0);
    send_line(10, 1'b0);
    send_line(LS, 1'b0);
    send_line(LS, 1'b0);
    compare("R3 random backpressure");
    bp_mode = 0;
  endtask

  task automatic t_stall_hold();
    logic [34:0] w0;
    bp_mode = 2;
    send_line(3, 1'b0);
    idle_in();
    w0 = exp_q[0];
    repeat (4) begin
      @(negedge clk);
      #2;
      chk("R3 held valid", 64'(out_valid_o), 64'd1);
      chk("R3 held word", 64'({out_err_o, out_eol_o, out_sof_o, out_data_o}), 64'(w0));
      chk("R9 input blocked", 64'(in_ready_o), 64'd0);
    end
    bp_mode = 0;
    compare("R3 release after stall");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_frame();
    t_wrap();
    t_resync();
    t_short();
    t_backpressure();
    t_stall_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule